// File: doc/BRIEF.md
# I2C Command Tag Stream Generator

This block turns one I2C message descriptor into the command byte stream that an I2C master engine reads from its output FIFO. The descriptor gives the target address (7-bit or 10-bit), the transfer direction, a byte count, a high-speed flag and a flag marking the final message of a combined transfer. The generator cuts the message into chunks of at most 256 bytes. Ahead of each chunk it places a data tag and a length byte. Ahead of the first chunk it also places the start sequence and the address bytes. For writes, the chunk's payload bytes, taken from a valid/ready byte port, follow its tags.

The tag and payload bytes are packed into 32-bit words, least significant byte first, and written to the FIFO with a write strobe that is held while the FIFO reports full. When a descriptor is accepted, the block reports the total number of tag bytes it will send and the number of tag bytes the engine will return on the receive side. At the start of each chunk it pulses a report of that chunk's tag count and data length.

Top module: `i2c_tag_streamer`

## Requirements
- R1: Tag byte values are START 0x81, HIGH_SPEED 0xFF, write data 0x82, write data with stop 0x83, read data 0x85 and read data with stop 0x87. The first chunk begins with START followed by the address byte {addr[6:0], rd}, where rd is 1 for a read.
- R2: With the high-speed flag set, the first chunk begins START, HIGH_SPEED, START, and the address byte(s) follow.
- R3: In 10-bit mode, a second address byte {5'b0, addr[9:7]} follows the first address byte.
- R4: A message of N bytes (1 to 65535) is sent as ceil(N/256) chunks. Every chunk except the last carries 256 bytes. Each chunk's data tag is followed by a length byte, which is 0 for a non-final chunk and N mod 256 for the final chunk.
- R5: Only the final chunk of a message flagged as the final message uses the stop form of the data tag. Every other chunk uses the plain form.
- R6: Bytes are packed into 32-bit words with the first byte in bits 7:0. A chunk's tags precede its payload. The word that holds the message's last byte is written even if it is partly filled, and its unused bytes are zero.
- R7: A read message sends tags only. The payload port never signals ready for it, and the reported receive tag count is 2 per chunk. For a write, the receive tag count is 0.
- R8: From the cycle after a descriptor is accepted, the transmit tag count equals lead + 2*chunks. Here lead is 2, plus 2 with high speed, plus 1 in 10-bit mode.
- R9: Each chunk start pulses chunk_vld_o once. It reports a tag count of lead+2 for the first chunk and 2 for later chunks, together with the chunk's data length (1 to 256).
- R10: While the FIFO reports full, a pending word and its strobe are held unchanged. No byte is lost or duplicated across any stall pattern.
- R11: A descriptor with length 0 raises err_o for one cycle in the cycle after the start, leaves the block idle and produces no words.
- R12: A start request while a message is in progress is ignored, and done_o pulses in the cycle the message's last byte is taken, after which busy_o drops.
- R13: After reset the block is idle, with no word strobe, no payload ready and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| msg_start_i | input | 1 | Descriptor valid; accepted when idle |
| msg_addr_i | input | 10 | Target address (bits 9:7 used in 10-bit mode only) |
| msg_ten_i | input | 1 | 10-bit addressing |
| msg_rd_i | input | 1 | 1 = read, 0 = write |
| msg_len_i | input | LEN_W | Message byte count |
| msg_hs_i | input | 1 | High-speed start sequence |
| msg_last_i | input | 1 | Final message of the transfer |
| pl_valid_i | input | 1 | Write payload byte valid |
| pl_data_i | input | 8 | Write payload byte |
| pl_ready_o | output | 1 | Payload byte taken this cycle when valid |
| fifo_full_i | input | 1 | Output FIFO full |
| word_valid_o | output | 1 | Word strobe; written when FIFO not full |
| word_data_o | output | WORD_W | Packed word |
| busy_o | output | 1 | Message in progress |
| done_o | output | 1 | Last byte of the message taken |
| err_o | output | 1 | Zero-length descriptor rejected |
| chunk_vld_o | output | 1 | Chunk start report strobe |
| chunk_tags_o | output | 3 | Tag bytes in this chunk |
| chunk_bytes_o | output | 9 | Data bytes in this chunk |
| tx_tags_o | output | LEN_W-4 | Total tag bytes sent for the message |
| rx_tags_o | output | LEN_W-4 | Tag bytes expected back on receive |

## Verification
The hardest situation to reach is a FIFO-full stall that lands exactly on a chunk boundary or on the zero-padded last word, while the payload source is also pausing. Only then does a lost or repeated byte show up as a shifted word. The directed scenarios drive the full flag with a cycle pattern that does not align with the 4-byte packing, and insert payload gaps with a different period. They use lengths of 256, 257 and 300, so that the stalls fall on chunk headers, on mid-word boundaries and on the padded tail. Each scenario compares the complete word stream against a model computed in the bench.

// File: rtl/i2c_tag_pkg.sv
package i2c_tag_pkg;
    localparam logic [7:0] TAG_START     = 8'h81;
    localparam logic [7:0] TAG_HISPEED   = 8'hFF;
    localparam logic [7:0] TAG_WR        = 8'h82;
    localparam logic [7:0] TAG_WR_STOP   = 8'h83;
    localparam logic [7:0] TAG_RD        = 8'h85;
    localparam logic [7:0] TAG_RD_STOP   = 8'h87;
    localparam int         CHUNK_LG      = 8;
    localparam int         CHUNK_MAX     = 1 << CHUNK_LG;
    localparam int         CLW           = CHUNK_LG + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_PAY  = 2'd2
    } seq_st_e;
endpackage

// File: rtl/i2c_tag_tally.sv
module i2c_tag_tally
    import i2c_tag_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int TAG_W = 12
) (
    input  logic [LEN_W-1:0] len_i,
    input  logic             hs_i,
    input  logic             ten_i,
    input  logic             rd_i,
    output logic [2:0]       lead_o,
    output logic [TAG_W-1:0] tx_o,
    output logic [TAG_W-1:0] rx_o
);
    localparam int CH_W = LEN_W - CHUNK_LG + 1;

    logic [CH_W-1:0] chunks;

    always_comb begin
        // ceil(len / CHUNK_MAX)
        chunks = CH_W'(len_i[LEN_W-1:CHUNK_LG]) + CH_W'(|len_i[CHUNK_LG-1:0]);
        lead_o = 3'd2 + (hs_i ? 3'd2 : 3'd0) + (ten_i ? 3'd1 : 3'd0);
        tx_o   = TAG_W'(lead_o) + (TAG_W'(chunks) << 1);
        rx_o   = rd_i ? (TAG_W'(chunks) << 1) : '0;
    end
endmodule

// File: rtl/i2c_tag_seq.sv
module i2c_tag_seq
    import i2c_tag_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int TAG_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [9:0]       addr_i,
    input  logic             rd_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             hs_i,
    input  logic             last_i,
    input  logic [2:0]       lead_i,
    input  logic [TAG_W-1:0] tx_i,
    input  logic [TAG_W-1:0] rx_i,
    input  logic             pl_valid_i,
    input  logic [7:0]       pl_data_i,
    output logic             pl_ready_o,
    output logic             b_vld_o,
    output logic [7:0]       b_data_o,
    output logic             b_last_o,
    input  logic             b_rdy_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic             chunk_vld_o,
    output logic [2:0]       chunk_tags_o,
    output logic [CLW-1:0]   chunk_bytes_o,
    output logic [TAG_W-1:0] tx_tags_o,
    output logic [TAG_W-1:0] rx_tags_o
);
    localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(CHUNK_MAX);

    typedef struct packed {
        seq_st_e          st;
        logic             first;
        logic [2:0]       hpos;
        logic [CLW-1:0]   pcnt;
        logic [CLW-1:0]   cl;
        logic [LEN_W-1:0] left;
        logic [9:0]       addr;
        logic             rd;
        logic             hs;
        logic             lastm;
        logic [2:0]       lead;
        logic [TAG_W-1:0] tx;
        logic [TAG_W-1:0] rx;
        logic             err;
    } seq_t;

    seq_t q, d;

    logic [7:0]       lseq [8];
    logic [2:0]       hdr_len;
    logic [2:0]       rel;
    logic             fin_chunk;
    logic [7:0]       dtag;
    logic [7:0]       lenbyte;
    logic [7:0]       hdr_byte;
    logic [LEN_W-1:0] left_after;
    logic             take;
    logic             end_chunk;

    always_comb begin
        for (int i = 0; i < 8; i++) lseq[i] = 8'h00;
        lseq[0] = TAG_START;
        if (q.hs) begin
            lseq[1] = TAG_HISPEED;
            lseq[2] = TAG_START;
            lseq[3] = {q.addr[6:0], q.rd};
            lseq[4] = {5'b0, q.addr[9:7]};
        end else begin
            lseq[1] = {q.addr[6:0], q.rd};
            lseq[2] = {5'b0, q.addr[9:7]};
        end

        hdr_len   = q.first ? (q.lead + 3'd2) : 3'd2;
        rel       = q.hpos - (q.first ? q.lead : 3'd0);
        fin_chunk = (q.left <= CHUNK_L);
        if (q.rd) dtag = (fin_chunk && q.lastm) ? TAG_RD_STOP : TAG_RD;
        else      dtag = (fin_chunk && q.lastm) ? TAG_WR_STOP : TAG_WR;
        lenbyte   = fin_chunk ? q.left[7:0] : 8'h00;

        if (q.first && (q.hpos < q.lead)) hdr_byte = lseq[q.hpos];
        else if (rel == 3'd0)             hdr_byte = dtag;
        else                              hdr_byte = lenbyte;

        left_after = q.left - LEN_W'(q.cl);

        d         = q;
        d.err     = 1'b0;
        b_vld_o   = 1'b0;
        b_data_o  = 8'h00;
        end_chunk = 1'b0;
        done_o    = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (len_i == '0) begin
                        d.err = 1'b1;
                    end else begin
                        d.st    = ST_HDR;
                        d.first = 1'b1;
                        d.hpos  = 3'd0;
                        d.pcnt  = '0;
                        d.left  = len_i;
                        d.cl    = (len_i > CHUNK_L) ? CLW'(CHUNK_MAX) : len_i[CLW-1:0];
                        d.addr  = addr_i;
                        d.rd    = rd_i;
                        d.hs    = hs_i;
                        d.lastm = last_i;
                        d.lead  = lead_i;
                        d.tx    = tx_i;
                        d.rx    = rx_i;
                    end
                end
            end
            ST_HDR: begin
                b_vld_o  = 1'b1;
                b_data_o = hdr_byte;
            end
            ST_PAY: begin
                b_vld_o  = pl_valid_i;
                b_data_o = pl_data_i;
            end
            default: d.st = ST_IDLE;
        endcase

        take = b_vld_o && b_rdy_i;

        if (take && (q.st == ST_HDR)) begin
            if (q.hpos == hdr_len - 3'd1) begin
                d.hpos = 3'd0;
                if (q.rd) begin
                    end_chunk = 1'b1;
                end else begin
                    d.st   = ST_PAY;
                    d.pcnt = '0;
                end
            end else begin
                d.hpos = q.hpos + 3'd1;
            end
        end

        if (take && (q.st == ST_PAY)) begin
            if (q.pcnt == q.cl - CLW'(1)) end_chunk = 1'b1;
            else                          d.pcnt    = q.pcnt + CLW'(1);
        end

        if (end_chunk) begin
            d.left = left_after;
            if (left_after == '0) begin
                d.st   = ST_IDLE;
                done_o = 1'b1;
            end else begin
                d.st    = ST_HDR;
                d.first = 1'b0;
                d.hpos  = 3'd0;
                d.pcnt  = '0;
                d.cl    = (left_after > CHUNK_L) ? CLW'(CHUNK_MAX) : left_after[CLW-1:0];
            end
        end

        b_last_o      = end_chunk && (left_after == '0);
        pl_ready_o    = (q.st == ST_PAY) && b_rdy_i;
        busy_o        = (q.st != ST_IDLE);
        err_o         = q.err;
        chunk_vld_o   = take && (q.st == ST_HDR) && (q.hpos == 3'd0);
        chunk_tags_o  = hdr_len;
        chunk_bytes_o = q.cl;
        tx_tags_o     = q.tx;
        rx_tags_o     = q.rx;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end
endmodule

// File: rtl/i2c_word_packer.sv
module i2c_word_packer #(
    parameter int WORD_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              b_vld_i,
    input  logic [7:0]        b_data_i,
    input  logic              b_last_i,
    output logic              b_rdy_o,
    input  logic              full_i,
    output logic              word_valid_o,
    output logic [WORD_W-1:0] word_data_o
);
    localparam int NB = WORD_W / 8;
    localparam int CW = (NB > 1) ? $clog2(NB) : 1;

    typedef struct packed {
        logic [NB-1:0][7:0] acc;
        logic [CW-1:0]      cnt;
        logic [WORD_W-1:0]  out;
        logic               ov;
    } pk_t;

    pk_t q, d;
    logic [NB-1:0][7:0] word;

    always_comb begin
        d       = q;
        b_rdy_o = !q.ov || !full_i;
        if (q.ov && !full_i) d.ov = 1'b0;

        word          = q.acc;
        word[q.cnt]   = b_data_i;

        if (b_vld_i && b_rdy_o) begin
            if ((q.cnt == CW'(NB - 1)) || b_last_i) begin
                d.out = word;
                d.ov  = 1'b1;
                d.acc = '0;
                d.cnt = '0;
            end else begin
                d.acc = word;
                d.cnt = q.cnt + CW'(1);
            end
        end

        word_valid_o = q.ov;
        word_data_o  = q.out;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end
endmodule

// File: rtl/i2c_tag_streamer.sv
module i2c_tag_streamer
    import i2c_tag_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int WORD_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              msg_start_i,
    input  logic [9:0]        msg_addr_i,
    input  logic              msg_ten_i,
    input  logic              msg_rd_i,
    input  logic [LEN_W-1:0]  msg_len_i,
    input  logic              msg_hs_i,
    input  logic              msg_last_i,
    input  logic              pl_valid_i,
    input  logic [7:0]        pl_data_i,
    output logic              pl_ready_o,
    input  logic              fifo_full_i,
    output logic              word_valid_o,
    output logic [WORD_W-1:0] word_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              chunk_vld_o,
    output logic [2:0]        chunk_tags_o,
    output logic [8:0]        chunk_bytes_o,
    output logic [LEN_W-5:0]  tx_tags_o,
    output logic [LEN_W-5:0]  rx_tags_o
);
    localparam int TAG_W = LEN_W - 4;

    logic [2:0]       lead;
    logic [TAG_W-1:0] tx_calc, rx_calc;
    logic             b_vld, b_last, b_rdy;
    logic [7:0]       b_data;

    i2c_tag_tally #(.LEN_W(LEN_W), .TAG_W(TAG_W)) tally_i (
        .len_i  (msg_len_i),
        .hs_i   (msg_hs_i),
        .ten_i  (msg_ten_i),
        .rd_i   (msg_rd_i),
        .lead_o (lead),
        .tx_o   (tx_calc),
        .rx_o   (rx_calc)
    );

    i2c_tag_seq #(.LEN_W(LEN_W), .TAG_W(TAG_W)) seq_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .start_i       (msg_start_i),
        .addr_i        (msg_addr_i),
        .rd_i          (msg_rd_i),
        .len_i         (msg_len_i),
        .hs_i          (msg_hs_i),
        .last_i        (msg_last_i),
        .lead_i        (lead),
        .tx_i          (tx_calc),
        .rx_i          (rx_calc),
        .pl_valid_i    (pl_valid_i),
        .pl_data_i     (pl_data_i),
        .pl_ready_o    (pl_ready_o),
        .b_vld_o       (b_vld),
        .b_data_o      (b_data),
        .b_last_o      (b_last),
        .b_rdy_i       (b_rdy),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .err_o         (err_o),
        .chunk_vld_o   (chunk_vld_o),
        .chunk_tags_o  (chunk_tags_o),
        .chunk_bytes_o (chunk_bytes_o),
        .tx_tags_o     (tx_tags_o),
        .rx_tags_o     (rx_tags_o)
    );

    i2c_word_packer #(.WORD_W(WORD_W)) pack_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .b_vld_i      (b_vld),
        .b_data_i     (b_data),
        .b_last_i     (b_last),
        .b_rdy_o      (b_rdy),
        .full_i       (fifo_full_i),
        .word_valid_o (word_valid_o),
        .word_data_o  (word_data_o)
    );
endmodule

// File: rtl/i2c_tag_streamer_chk.sv
module i2c_tag_streamer_chk #(
    parameter int LEN_W  = 16,
    parameter int WORD_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              pl_ready_o,
    input logic              fifo_full_i,
    input logic              word_valid_o,
    input logic [WORD_W-1:0] word_data_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic              chunk_vld_o,
    input logic [2:0]        chunk_tags_o,
    input logic [8:0]        chunk_bytes_o,
    input logic [LEN_W-5:0]  tx_tags_o,
    input logic [LEN_W-5:0]  rx_tags_o
);
    p_hold_full_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_valid_o && fifo_full_i) |=> (word_valid_o && $stable(word_data_o)));

    p_read_no_pay_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && rx_tags_o != '0) |-> !pl_ready_o);

    p_err_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> !busy_o);

    p_done_ends_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !busy_o);

    p_chunk_tags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chunk_vld_o |-> (chunk_tags_o >= 3'd2 && chunk_tags_o <= 3'd7));

    p_chunk_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chunk_vld_o |-> (chunk_bytes_o != 9'd0 && chunk_bytes_o <= 9'd256));

    p_tx_floor_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (tx_tags_o >= (LEN_W-4)'(4)));
endmodule

bind i2c_tag_streamer i2c_tag_streamer_chk #(.LEN_W(LEN_W), .WORD_W(WORD_W)) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pl_ready_o    (pl_ready_o),
    .fifo_full_i   (fifo_full_i),
    .word_valid_o  (word_valid_o),
    .word_data_o   (word_data_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o),
    .chunk_vld_o   (chunk_vld_o),
    .chunk_tags_o  (chunk_tags_o),
    .chunk_bytes_o (chunk_bytes_o),
    .tx_tags_o     (tx_tags_o),
    .rx_tags_o     (rx_tags_o)
);

// File: tb/i2c_tag_streamer_tb_top.sv
module i2c_tag_streamer_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LEN_W = 16;
    localparam int TAG_W = LEN_W - 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [9:0]       addr = '0;
    logic             ten = 1'b0;
    logic             rd = 1'b0;
    logic [LEN_W-1:0] len = '0;
    logic             hs = 1'b0;
    logic             last = 1'b0;
    logic             pl_valid = 1'b0;
    logic [7:0]       pl_data = '0;
    logic             pl_ready;
    logic             full = 1'b0;
    logic             word_valid;
    logic [31:0]      word_data;
    logic             busy, done, err, chunk_vld;
    logic [2:0]       chunk_tags;
    logic [8:0]       chunk_bytes;
    logic [TAG_W-1:0] tx_tags, rx_tags;

    int n_chk = 0;
    int n_err = 0;

    logic [7:0]  exp_b[$];
    logic [31:0] exp_w[$];
    logic [31:0] got_w[$];
    int          got_ct[$];
    int          got_cb[$];

    always #2 clk = ~clk;

    i2c_tag_streamer #(.LEN_W(LEN_W), .WORD_W(32)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .msg_start_i(start), .msg_addr_i(addr),
        .msg_ten_i(ten), .msg_rd_i(rd), .msg_len_i(len), .msg_hs_i(hs),
        .msg_last_i(last), .pl_valid_i(pl_valid), .pl_data_i(pl_data),
        .pl_ready_o(pl_ready), .fifo_full_i(full), .word_valid_o(word_valid),
        .word_data_o(word_data), .busy_o(busy), .done_o(done), .err_o(err),
        .chunk_vld_o(chunk_vld), .chunk_tags_o(chunk_tags),
        .chunk_bytes_o(chunk_bytes), .tx_tags_o(tx_tags), .rx_tags_o(rx_tags)
    );

    function automatic logic [7:0] pay(int k);
        return 8'((k * 37 + 5) & 255);
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(!word_valid && !busy && !pl_ready && !err && !done, "R13", "idle after reset",
              {word_valid, busy, pl_ready, err, done}, 0);
    endtask

    task automatic run_msg(string req, logic [9:0] a, bit t, bit r, int n, bit h, bit l,
                           bit stall, bit gaps, bit inject);
        int chunks, lead, k, pidx, cyc, mism, first_bad, ready_in_read, err_seen;
        bit hsk, done_seen;
        chunks = (n + 255) / 256;
        lead   = 2 + (h ? 2 : 0) + (t ? 1 : 0);
        exp_b.delete(); exp_w.delete(); got_w.delete(); got_ct.delete(); got_cb.delete();
        k = 0;
        for (int c = 0; c < chunks; c++) begin
            bit fin;
            int clen;
            fin  = (c == chunks - 1);
            clen = fin ? (n - 256 * c) : 256;
            if (c == 0) begin
                exp_b.push_back(8'h81);
                if (h) begin exp_b.push_back(8'hFF); exp_b.push_back(8'h81); end
                exp_b.push_back({a[6:0], r});
                if (t) exp_b.push_back({5'b0, a[9:7]});
            end
            if (r) exp_b.push_back((fin && l) ? 8'h87 : 8'h85);
            else   exp_b.push_back((fin && l) ? 8'h83 : 8'h82);
            exp_b.push_back(fin ? 8'(n % 256) : 8'h00);
            if (!r) for (int j = 0; j < clen; j++) begin exp_b.push_back(pay(k)); k++; end
        end
        for (int i = 0; i < exp_b.size(); i += 4) begin
            logic [31:0] w;
            w = '0;
            for (int b = 0; b < 4; b++)
                if (i + b < exp_b.size()) w[8*b +: 8] = exp_b[i + b];
            exp_w.push_back(w);
        end

        @(posedge clk); #1;
        addr = a; ten = t; rd = r; len = LEN_W'(n); hs = h; last = l; start = 1'b1;
        pidx = 0;
        pl_valid = !r; pl_data = pay(0);
        @(posedge clk); #1;
        start = 1'b0;
        done_seen = 0; ready_in_read = 0; err_seen = 0;
        for (cyc = 0; cyc < 6000; cyc++) begin
            @(negedge clk);
            if (cyc == 0) begin
                check(busy, req, "busy after accept", busy, 1);
                check(tx_tags == TAG_W'(lead + 2 * chunks), "R8", "tx tag count", tx_tags, lead + 2 * chunks);
                check(rx_tags == TAG_W'(r ? 2 * chunks : 0), "R7", "rx tag count", rx_tags, r ? 2 * chunks : 0);
            end
            if (word_valid && !full) got_w.push_back(word_data);
            if (chunk_vld) begin got_ct.push_back(chunk_tags); got_cb.push_back(chunk_bytes); end
            if (r && pl_ready) ready_in_read++;
            if (err) err_seen++;
            hsk = pl_valid && pl_ready;
            if (done) done_seen = 1;
            if (done_seen && !word_valid && got_w.size() >= exp_w.size()) break;
            @(posedge clk); #1;
            if (hsk) pidx++;
            pl_valid = !r && (pidx < n) && !(gaps && (cyc % 5 == 1));
            pl_data  = pay(pidx);
            full     = stall && (cyc % 3 != 0);
            if (inject && cyc == 8) begin
                start = 1'b1; addr = 10'h155; rd = ~r; len = 16'd0; hs = 1'b1; last = ~l;
            end else begin
                start = 1'b0;
            end
        end
        @(posedge clk); #1;
        full = 1'b0; pl_valid = 1'b0; start = 1'b0;

        check(done_seen, "R12", "done pulse seen", done_seen, 1);
        check(got_w.size() == exp_w.size(), req, "word count", got_w.size(), exp_w.size());
        mism = 0; first_bad = -1;
        for (int i = 0; i < exp_w.size() && i < got_w.size(); i++)
            if (got_w[i] !== exp_w[i]) begin
                mism++;
                if (first_bad < 0) first_bad = i;
            end
        if (first_bad >= 0)
            check(0, req, $sformatf("word %0d", first_bad), got_w[first_bad], exp_w[first_bad]);
        else
            check(1, req, "word stream", 0, 0);
        check(got_ct.size() == chunks, "R9", "chunk report count", got_ct.size(), chunks);
        for (int c = 0; c < chunks && c < got_ct.size(); c++) begin
            int et, eb;
            et = (c == 0) ? lead + 2 : 2;
            eb = (c == chunks - 1) ? n - 256 * c : 256;
            check(got_ct[c] == et, "R9", $sformatf("chunk %0d tags", c), got_ct[c], et);
            check(got_cb[c] == eb, "R4", $sformatf("chunk %0d bytes", c), got_cb[c], eb);
        end
        if (r) check(ready_in_read == 0, "R7", "payload ready during read", ready_in_read, 0);
        if (inject) check(err_seen == 0, "R12", "start while busy ignored", err_seen, 0);
        @(negedge clk);
        check(!busy && !word_valid, "R12", "idle after message", {busy, word_valid}, 0);
    endtask

    task automatic test_zero_len();
        int words;
        @(posedge clk); #1;
        addr = 10'h21; rd = 1'b0; len = '0; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        check(err && !busy, "R11", "error pulse on zero length", {err, busy}, 2);
        words = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (word_valid || busy) words++;
        end
        check(words == 0, "R11", "no words for zero length", words, 0);
        check(!err, "R11", "error pulse is single cycle", err, 0);
    endtask

    initial begin
        #800000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        @(posedge clk); #1;
        rst_n = 1'b1;
        // R1 R5 R6: short 7-bit write, final message, padded tail
        run_msg("R1/R5/R6", 10'h05A, 0, 0, 3, 0, 1, 0, 0, 0);
        // R4 R5 R10 R12: two chunks, not final, FIFO stalls, start while busy
        run_msg("R4/R10", 10'h033, 0, 0, 300, 0, 0, 1, 1, 1);
        // R2 R3 R7: high-speed 10-bit read, two full chunks
        run_msg("R2/R3/R7", 10'h2C5, 1, 1, 512, 1, 1, 1, 0, 0);
        // R4: exactly one full chunk, length byte 0
        run_msg("R4/R6", 10'h07F, 0, 0, 256, 0, 1, 0, 1, 0);
        // R2 R10: 257 bytes, high speed, stalls and payload gaps
        run_msg("R2/R10", 10'h011, 0, 0, 257, 1, 1, 1, 1, 0);
        // R5: read not final keeps plain tag
        run_msg("R5/R7", 10'h3FF, 1, 1, 5, 0, 0, 0, 0, 0);
        test_zero_len();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule